// File: doc/BRIEF.md
# Serial Presence-Detect EEPROM Slave with One-Time Lower-Half Lock

This block models a 256-byte configuration memory that answers on an I2C bus as a slave. It oversamples SCL and SDA with the system clock and finds start and stop conditions. It matches the 7-bit slave address against a fixed type nibble and three strap inputs, and returns data through an open-drain output enable: high means pull SDA low. A master can write one byte or a page of up to 16 bytes, and can read from the current pointer, from a chosen address, or through a sequential stream that runs on past the end of the array.

Written bytes wait in a one-page staging buffer. A stop condition commits them, and the block then stays deaf to its address for a fixed number of clocks, which models the self-timed programming cycle. A master finds out that the cycle has finished by polling the address. A second address type with the same straps reaches a set-once lock. The lock makes the lower 128 bytes read-only until the next power-on reset.

Top module: `eep_spd_slave`

## Requirements
- R1: The slave address byte is {type[3:0], dev[2:0], rw} with rw=1 for read, and the memory type is 4'b1010. The block pulls SDA low in the ninth clock only when dev equals addr_strap_i. When they differ it leaves SDA released until the next start or stop.
- R2: A byte write sends the write address, then a word address, then one data byte, then a stop. It stores the byte at that word address, and each of the three bytes is acknowledged.
- R3: In a write, only the low 4 address bits advance. A 17th or later byte wraps to the start of the same 16-byte page and overwrites the bytes written earlier.
- R4: After a stop that ends a write holding at least one data byte, the slave address is not acknowledged for WRITE_CYCLES clocks, and after that it is acknowledged again. A write cut short by a repeated start is discarded and starts no commit cycle.
- R5: A random read reads from the word address just sent. A current-address read reads from one past the last byte transferred.
- R6: In a sequential read each master ACK advances the 8-bit pointer, and 0xFF rolls over to 0x00.
- R7: A master NACK after a read byte releases SDA. A following stop returns the block to idle, ready for a new transaction.
- R8: The lock type 4'b0110 with rw=0 is acknowledged while the block is unlocked, and the stop that ends that transaction sets the lock. Once the lock is set, that address is not acknowledged. Writes to 0x00–0x7F are acknowledged but leave the array unchanged, and 0x80–0xFF stay writable.
- R9: rst_ni alone clears the lock. Reset also fills the array with 0xFF, sets the pointer to 0 and releases SDA.
- R10: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_strap_i | input | 3 | Device select straps compared with the address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A state machine that is one bit out of step moves the acknowledge off the ninth clock. The master sees this at once as a missing or extra ACK on the next byte boundary. A wrong page pointer or a broken lock does not show on the bus during the write. It appears only when a later read returns a byte that differs from the model, after the commit cycle has ended. A commit timer of the wrong length shows up as a different number of address polls before the first ACK.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 8;
  localparam int OFS_W  = 4;
  localparam int PAGE_N = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_WADDR, ST_ACK_WADDR,
    ST_WDATA, ST_ACK_WDATA, ST_RDATA, ST_RACK, ST_WAIT
  } eep_st_e;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_N-1];
      sda_q  <= sda_sh[SYNC_N-1];
    end
  end

  assign scl_s      = scl_sh[SYNC_N-1];
  assign sda_o      = sda_sh[SYNC_N-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 1200000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_clr_i,
  input  logic              stage_we_i,
  input  logic [OFS_W-1:0]  stage_ofs_i,
  input  logic [7:0]        stage_data_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              commit_i,
  input  logic              lock_set_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              locked_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  logic [7:0]        mem_q   [DEPTH];
  logic [7:0]        stage_q [PAGE_N];
  logic [PAGE_N-1:0] stage_v_q;
  logic              locked_q;
  logic [TW-1:0]     timer_q;
  logic              page_open;

  // lower half of the array is closed once locked
  assign page_open = !(locked_q && !page_i[PAGE_W-1]);

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[g]   <= 8'h00;
        stage_v_q[g] <= 1'b0;
      end else if (stage_clr_i || commit_i) begin
        stage_v_q[g] <= 1'b0;
      end else if (stage_we_i && stage_ofs_i == OFS_W'(g)) begin
        stage_q[g]   <= stage_data_i;
        stage_v_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i && page_open) begin
      for (int s = 0; s < PAGE_N; s++)
        if (stage_v_q[s]) mem_q[{page_i, OFS_W'(s)}] <= stage_q[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      timer_q  <= '0;
    end else begin
      locked_q <= locked_q | lock_set_i;
      if (commit_i || lock_set_i) timer_q <= TW'(WRITE_CYCLES);
      else if (timer_q != '0)     timer_q <= timer_q - TW'(1);
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign locked_o  = locked_q;
  assign busy_o    = (timer_q != '0);
endmodule

// File: rtl/eep_spd_slave.sv
module eep_spd_slave
  import eep_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 1200000,
  parameter logic [3:0]  MEM_TYPE     = 4'b1010,
  parameter logic [3:0]  LOCK_TYPE    = 4'b0110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_strap_i,
  output logic       sda_oe_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data;
  logic locked, busy;

  eep_st_e     st_q;
  logic [3:0]  cnt_q;
  logic [7:0]  sh_q, tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic rw_q, tgt_lock_q, wr_pend_q, lock_pend_q, oe_q, mack_q;
  logic hit_mem, hit_lock, byte_done;

  eep_bus_sense #(.SYNC_N(2)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eep_store #(.WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk_i, .rst_ni,
    .stage_clr_i (start_det),
    .stage_we_i  (st_q == ST_WDATA && byte_done && !tgt_lock_q),
    .stage_ofs_i (ptr_q[OFS_W-1:0]),
    .stage_data_i(sh_q),
    .page_i      (ptr_q[ADDR_W-1:OFS_W]),
    .commit_i    (stop_det && wr_pend_q),
    .lock_set_i  (stop_det && lock_pend_q),
    .rd_addr_i   (ptr_q),
    .rd_data_o   (rd_data),
    .locked_o    (locked),
    .busy_o      (busy)
  );

  assign byte_done = scl_fall && cnt_q == 4'd8;
  assign hit_mem   = sh_q[7:4] == MEM_TYPE && sh_q[3:1] == addr_strap_i && !busy;
  assign hit_lock  = sh_q[7:4] == LOCK_TYPE && sh_q[3:1] == addr_strap_i &&
                     !sh_q[0] && !busy && !locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; ptr_q <= '0;
      rw_q <= 1'b0; tgt_lock_q <= 1'b0; wr_pend_q <= 1'b0;
      lock_pend_q <= 1'b0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else if (start_det) begin
      st_q <= ST_DEV; cnt_q <= '0; oe_q <= 1'b0;
      wr_pend_q <= 1'b0; lock_pend_q <= 1'b0; tgt_lock_q <= 1'b0;
    end else if (stop_det) begin
      st_q <= ST_IDLE; oe_q <= 1'b0;
      wr_pend_q <= 1'b0; lock_pend_q <= 1'b0;
    end else begin
      // receive states shift on rising SCL
      if (scl_rise && (st_q == ST_DEV || st_q == ST_WADDR || st_q == ST_WDATA)) begin
        sh_q  <= {sh_q[6:0], sda_s};
        cnt_q <= cnt_q + 4'd1;
      end
      unique case (st_q)
        ST_DEV: if (byte_done) begin
          if (hit_mem || hit_lock) begin
            oe_q <= 1'b1; st_q <= ST_ACK_DEV;
            rw_q <= sh_q[0]; tgt_lock_q <= hit_lock;
          end else st_q <= ST_WAIT;
        end
        ST_ACK_DEV: if (scl_fall) begin
          cnt_q <= '0;
          if (rw_q) begin
            tx_q <= rd_data; oe_q <= ~rd_data[7]; st_q <= ST_RDATA;
          end else begin
            oe_q <= 1'b0; st_q <= ST_WADDR;
            if (tgt_lock_q) lock_pend_q <= 1'b1;
          end
        end
        ST_WADDR: if (byte_done) begin
          if (!tgt_lock_q) ptr_q <= sh_q;
          oe_q <= 1'b1; st_q <= ST_ACK_WADDR;
        end
        ST_WDATA: if (byte_done) begin
          if (!tgt_lock_q) begin
            ptr_q     <= {ptr_q[ADDR_W-1:OFS_W], ptr_q[OFS_W-1:0] + OFS_W'(1)};
            wr_pend_q <= 1'b1;
          end
          oe_q <= 1'b1; st_q <= ST_ACK_WDATA;
        end
        ST_ACK_WADDR, ST_ACK_WDATA: if (scl_fall) begin
          oe_q <= 1'b0; cnt_q <= '0; st_q <= ST_WDATA;
        end
        ST_RDATA: if (scl_fall) begin
          if (cnt_q == 4'd7) begin
            oe_q <= 1'b0; st_q <= ST_RACK; ptr_q <= ptr_q + ADDR_W'(1);
          end else begin
            cnt_q <= cnt_q + 4'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
            oe_q  <= ~tx_q[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              cnt_q <= '0; tx_q <= rd_data; oe_q <= ~rd_data[7]; st_q <= ST_RDATA;
            end else st_q <= ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/eep_spd_slave_chk.sv
module eep_spd_slave_chk
  import eep_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 1200000
) (
  input logic    clk_i,
  input logic    rst_ni,
  input logic    scl_i,
  input logic    stop_i,
  input logic    sda_oe_i,
  input logic    busy_i,
  input logic    locked_i,
  input eep_st_e st_i,
  input logic    tgt_lock_i
);
  logic [31:0] busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= '0;
    else if (busy_i) busy_len <= busy_len + 32'd1;
    else             busy_len <= '0;
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> locked_i);

  // R4
  busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> st_i != ST_ACK_DEV);

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_len == WRITE_CYCLES);

  // R7
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_i == ST_IDLE && !sda_oe_i));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !$past(scl_i));

  // R8
  lock_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ACK_DEV && tgt_lock_i) |-> !locked_i);
endmodule

bind eep_spd_slave eep_spd_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .stop_i    (stop_det),
  .sda_oe_i  (sda_oe_o),
  .busy_i    (busy),
  .locked_i  (locked),
  .st_i      (st_q),
  .tgt_lock_i(tgt_lock_q)
);

// File: tb/eep_spd_slave_bench.sv
module eep_spd_slave_bench;
  localparam int          H      = 10;
  localparam int unsigned WCYC   = 400;
  localparam logic [2:0]  STRAP  = 3'b101;
  localparam logic [7:0]  DEV_W  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0]  DEV_R  = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0]  LOCK_W = {4'b0110, STRAP, 1'b0};
  localparam int          NV     = 6;
  // {word address, data}
  localparam logic [15:0] VEC [NV] = '{16'h00_11, 16'h7F_22, 16'h80_33,
                                       16'hC5_44, 16'hFF_55, 16'h3A_66};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_line;
  int   n_run = 0, n_fail = 0, oe_bad = 0, cyc = 0;
  bit   done = 1'b0;
  logic [7:0] pbuf [32];
  logic [7:0] rbuf [32];

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  eep_spd_slave #(.WRITE_CYCLES(WCYC)) u_eep_spd_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_strap_i(STRAP), .sda_oe_o(sda_oe)
  );

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && sda_oe !== oe_prev && scl) oe_bad <= oe_bad + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1; w(H); scl = 1; w(H); m_sda = 0; w(H); scl = 0; w(2);
  endtask

  task automatic i2c_stop;
    m_sda = 0; w(H); scl = 1; w(H); m_sda = 1; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(H); scl = 1; w(H); scl = 0; w(2);
    end
    m_sda = 1; w(H); scl = 1; w(H/2); ack = (sda_line == 1'b0);
    w(H/2); scl = 0; w(2);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl = 1; w(H/2); b[i] = sda_line; w(H/2); scl = 0; w(2);
    end
    m_sda = mack ? 1'b0 : 1'b1; w(H); scl = 1; w(H); scl = 0; w(2); m_sda = 1;
  endtask

  task automatic poll_ready(output int tries);
    logic a;
    tries = 0;
    for (int k = 0; k < 100; k++) begin
      i2c_start; send_byte(DEV_W, a); i2c_stop;
      if (a) break;
      tries++;
    end
  endtask

  // page buffer pbuf[0..n-1] written from addr; returns AND of all acks
  task automatic page_write(input logic [7:0] addr, input int n, output logic ok);
    logic a;
    i2c_start; send_byte(DEV_W, a); ok = a;
    send_byte(addr, a); ok &= a;
    for (int i = 0; i < n; i++) begin send_byte(pbuf[i], a); ok &= a; end
    i2c_stop;
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n);
    logic a;
    i2c_start; send_byte(DEV_W, a); send_byte(addr, a);
    i2c_start; send_byte(DEV_R, a);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop;
  endtask

  task automatic cur_read(input int n);
    logic a;
    i2c_start; send_byte(DEV_R, a);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop;
  endtask

  initial begin
    while (!done && cyc < 190000) @(negedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic a, ok;
    int t;
    w(5); rst_n = 1; w(5);

    // R9: reset releases SDA and fills the array with 0xFF
    check("R9 oe after reset", sda_oe, 1'b0);
    rand_read(8'h10, 1);
    check("R9 erased content", rbuf[0], 8'hFF);

    // R1: wrong strap value not acknowledged
    i2c_start; send_byte({4'b1010, ~STRAP, 1'b0}, a);
    check("R1 strap mismatch nack", a, 1'b0);
    check("R1 sda released", sda_oe, 1'b0);
    i2c_stop;

    // R2/R4/R5: table of byte writes and random reads
    for (int v = 0; v < NV; v++) begin
      pbuf[0] = VEC[v][7:0];
      page_write(VEC[v][15:8], 1, ok);
      check("R2 byte write acks", ok, 1'b1);
      i2c_start; send_byte(DEV_W, a); i2c_stop;
      check("R4 busy after commit nack", a, 1'b0);
      poll_ready(t);
      rand_read(VEC[v][15:8], 1);
      check("R5 random read data", rbuf[0], VEC[v][7:0]);
    end

    // R4: commit window length seen as polls (each poll ~ 250 clocks)
    pbuf[0] = 8'h5A; page_write(8'h60, 1, ok);
    poll_ready(t);
    check("R4 poll count in window", (t >= 1 && t <= 2), 1'b1);

    // R3/R6: full page write then sequential read
    for (int i = 0; i < 16; i++) pbuf[i] = 8'hA0 + 8'(i);
    page_write(8'h40, 16, ok); poll_ready(t);
    rand_read(8'h40, 16);
    for (int i = 0; i < 16; i++) check("R3 page write byte", rbuf[i], 8'hA0 + 8'(i));

    // R3: 18 bytes from 0x3E wrap inside page 0x30
    for (int i = 0; i < 18; i++) pbuf[i] = 8'h50 + 8'(i);
    page_write(8'h3E, 18, ok); poll_ready(t);
    rand_read(8'h30, 16);
    for (int i = 0; i < 14; i++) check("R3 wrapped page body", rbuf[i], 8'h52 + 8'(i));
    check("R3 wrap overwrite 0x3E", rbuf[14], 8'h60);
    check("R3 wrap overwrite 0x3F", rbuf[15], 8'h61);

    // R6: rollover 0xFF -> 0x00; R5: current address follows
    rand_read(8'hFE, 3);
    check("R6 read 0xFE", rbuf[0], 8'hFF);
    check("R6 read 0xFF", rbuf[1], 8'h55);
    check("R6 rollover to 0x00", rbuf[2], 8'h11);
    check("R7 released after nack stop", sda_oe, 1'b0);
    cur_read(1);
    check("R5 current address read", rbuf[0], 8'hFF);

    // R4: repeated start discards the write, no commit cycle
    i2c_start; send_byte(DEV_W, a); send_byte(8'h90, a); send_byte(8'h12, a);
    i2c_start; i2c_stop;
    i2c_start; send_byte(DEV_W, a); i2c_stop;
    check("R4 no busy after abort", a, 1'b1);
    rand_read(8'h90, 1);
    check("R4 aborted byte not stored", rbuf[0], 8'hFF);

    // R8: set the lock
    i2c_start; send_byte(LOCK_W, a); i2c_stop;
    check("R8 lock address ack", a, 1'b1);
    poll_ready(t);
    pbuf[0] = 8'h77; page_write(8'h05, 1, ok); poll_ready(t);
    check("R8 locked write acked", ok, 1'b1);
    rand_read(8'h05, 1);
    check("R8 locked byte unchanged", rbuf[0], 8'hFF);
    pbuf[0] = 8'h66; page_write(8'h85, 1, ok); poll_ready(t);
    rand_read(8'h85, 1);
    check("R8 upper half writable", rbuf[0], 8'h66);
    i2c_start; send_byte(LOCK_W, a); i2c_stop;
    check("R8 lock address nack when locked", a, 1'b0);

    // R9: only reset clears the lock
    w(4); rst_n = 0; w(4); rst_n = 1; w(4);
    pbuf[0] = 8'h77; page_write(8'h05, 1, ok); poll_ready(t);
    rand_read(8'h05, 1);
    check("R9 lock cleared by reset", rbuf[0], 8'h77);
    rand_read(8'h85, 1);
    check("R9 array refilled", rbuf[0], 8'hFF);

    // R10: output enable never moved with SCL high
    check("R10 oe change with scl high", oe_bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule